// File: doc/BRIEF.md
# Indirect Switch Register Access Sequencer

This block lets on-chip logic read and write the 16-bit internal registers of an attached managed Ethernet switch. The switch cannot be reached directly: its registers are only visible through a small window of Clause-22 management registers. A client hands the block a single request. That request carries a direction, a 16-bit internal address and, for a write, a 16-bit data word. The block expands the request into a fixed script of single management-register operations and hands them, one at a time, to a separate frame master.

Each script step waits for an acknowledgement from the frame master. The acknowledgement returns read data and an error bit. A failing step ends the script at once. The client then sees a one-cycle completion pulse with an error flag and, for a successful read, the fetched word. The port address of the switch is a static configuration input. It is captured when a request is accepted and used unchanged for every step of that request.

Top module: `mdio_indirect_seq`

## Requirements
- R1: After synchronous active-high reset the block is idle: `req_ready` is 1, `mdo_valid` is 0 and `rsp_done` is 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is high only while no script runs. A request presented while busy has no effect on the operations issued or on the response.
- R3: The first step of every script is a write (`mdo_read`=0) of 0x000E to management register 31.
- R4: The second step is a write of the 16-bit internal address to management register 23.
- R5: For a write request, the third step writes the data word to register 24. The fourth step writes 0x0003 to register 21. A successful write completes with `rsp_err`=0 and `rsp_rdata`=0.
- R6: For a read request, the third step writes 0x0001 to register 21. The fourth step is a read (`mdo_read`=1) of register 25. A successful read completes with `rsp_err`=0 and `rsp_rdata` equal to the data returned with that read's acknowledgement.
- R7: If an acknowledgement carries `mdo_err`=1, no later step of that script is issued. The request completes with `rsp_err`=1 and `rsp_rdata`=0.
- R8: Every step of a request carries on `mdo_phy` the value `phy_addr` had when the request was accepted. Later changes of `phy_addr` have no effect on it.
- R9: While `mdo_valid` is high and no acknowledgement has arrived, the operation fields stay stable and `mdo_valid` stays high.
- R10: Each accepted request produces exactly one `rsp_done` pulse, one cycle long. The pulse comes in the cycle after the acknowledgement that ends the script.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Internal register address |
| req_wdata | input | 16 | Internal register data for writes |
| phy_addr | input | 5 | Switch port address, sampled on accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, 0 for writes and errors |
| rsp_err | output | 1 | Completion carries an error |
| mdo_valid | output | 1 | Management operation pending |
| mdo_read | output | 1 | 1 = register read, 0 = register write |
| mdo_phy | output | 5 | Port address of the operation |
| mdo_reg | output | 5 | Management register number |
| mdo_wdata | output | 16 | Data for a register write |
| mdo_ack | input | 1 | Operation completed by the frame master |
| mdo_rdata | input | 16 | Data returned with the acknowledgement |
| mdo_err | input | 1 | Operation failed |

## Verification
The hardest case to reach from the ports is an abort at each of the four script positions, for both directions. The bench's responder fails exactly the step selected by each request, for every position. A read of the same address follows each aborted write, which shows whether the commit took effect. Acknowledgement latency varies between requests so that steps both wait and chain back to back. While a script runs, the bench keeps driving stray requests and changing `phy_addr`. This shows that neither reaches the bus.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;
  localparam int AW = 16;   // internal address width
  localparam int DW = 16;   // data width
  localparam int PW = 5;    // port address width
  localparam int RW = 5;    // management register number width

  typedef enum logic [2:0] {ST_IDLE, ST_MODE, ST_ADDR, ST_WDATA, ST_CMD, ST_FETCH} step_e;

  localparam logic [RW-1:0] REG_CTL_SEL = RW'(31);
  localparam logic [RW-1:0] REG_IADDR   = RW'(23);
  localparam logic [RW-1:0] REG_IWDATA  = RW'(24);
  localparam logic [RW-1:0] REG_CTL_GO  = RW'(21);
  localparam logic [RW-1:0] REG_IRDATA  = RW'(25);

  localparam logic [DW-1:0] OPC_SELECT = DW'(16'h000E);
  localparam logic [DW-1:0] OPC_READ   = DW'(16'h0001);
  localparam logic [DW-1:0] OPC_WRITE  = DW'(16'h0003);

  // step that follows s once s has been acknowledged without error
  function automatic step_e next_step(step_e s, logic wr);
    case (s)
      ST_MODE:  return ST_ADDR;
      ST_ADDR:  return wr ? ST_WDATA : ST_CMD;
      ST_WDATA: return ST_CMD;
      ST_CMD:   return wr ? ST_IDLE : ST_FETCH;
      default:  return ST_IDLE;
    endcase
  endfunction

  function automatic logic is_last(step_e s, logic wr);
    return (s != ST_IDLE) && (next_step(s, wr) == ST_IDLE);
  endfunction

  function automatic logic [RW-1:0] step_reg(step_e s);
    case (s)
      ST_MODE:  return REG_CTL_SEL;
      ST_ADDR:  return REG_IADDR;
      ST_WDATA: return REG_IWDATA;
      ST_CMD:   return REG_CTL_GO;
      ST_FETCH: return REG_IRDATA;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] step_word(step_e s, logic wr,
                                              logic [AW-1:0] addr, logic [DW-1:0] wd);
    case (s)
      ST_MODE:  return OPC_SELECT;
      ST_ADDR:  return DW'(addr);
      ST_WDATA: return wd;
      ST_CMD:   return wr ? OPC_WRITE : OPC_READ;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/mdio_seq_fsm.sv
module mdio_seq_fsm
  import mdio_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  wr,
  input  logic  ack,
  input  logic  err,
  output step_e step,
  output logic  hit,
  output logic  finish
);
  step_e nxt;

  assign hit    = ack && (step != ST_IDLE);
  assign finish = hit && (err || is_last(step, wr));

  always_comb begin
    nxt = step;
    if (step == ST_IDLE) begin
      if (start) nxt = ST_MODE;
    end else if (hit) begin
      nxt = err ? ST_IDLE : next_step(step, wr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_IDLE;
    else     step <= nxt;
  end

  // R7
  abort_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && err) |=> (step == ST_IDLE));

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step != ST_IDLE && !ack) |=> (step == $past(step)));
endmodule

// File: rtl/mdio_seq_opgen.sv
module mdio_seq_opgen
  import mdio_seq_pkg::*;
(
  input  step_e          step,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [PW-1:0]  phy,
  output logic           op_valid,
  output logic           op_read,
  output logic [PW-1:0]  op_phy,
  output logic [RW-1:0]  op_reg,
  output logic [DW-1:0]  op_wdata
);
  assign op_valid = (step != ST_IDLE);
  assign op_read  = (step == ST_FETCH);
  assign op_phy   = phy;
  assign op_reg   = step_reg(step);
  assign op_wdata = step_word(step, wr, addr, wdata);
endmodule

// File: rtl/mdio_indirect_seq.sv
module mdio_indirect_seq
  import mdio_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [15:0]   req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [4:0]    phy_addr,
  output logic          rsp_done,
  output logic [15:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          mdo_valid,
  output logic          mdo_read,
  output logic [4:0]    mdo_phy,
  output logic [4:0]    mdo_reg,
  output logic [15:0]   mdo_wdata,
  input  logic          mdo_ack,
  input  logic [15:0]   mdo_rdata,
  input  logic          mdo_err
);
  step_e         step;
  logic          accept, hit, finish;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [PW-1:0] phy_q;

  assign req_ready = (step == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      phy_q   <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      phy_q   <= phy_addr;
    end
  end

  mdio_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(accept), .wr(wr_q),
    .ack(mdo_ack), .err(mdo_err), .step(step), .hit(hit), .finish(finish)
  );

  mdio_seq_opgen u_opgen (
    .step(step), .wr(wr_q), .addr(addr_q), .wdata(wdata_q), .phy(phy_q),
    .op_valid(mdo_valid), .op_read(mdo_read), .op_phy(mdo_phy),
    .op_reg(mdo_reg), .op_wdata(mdo_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= finish;
      if (finish) begin
        rsp_err   <= mdo_err;
        rsp_rdata <= (mdo_err || wr_q) ? '0 : mdo_rdata;
      end
    end
  end

  // R3
  first_step_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mdo_valid && !mdo_read && mdo_reg == 5'd31 && mdo_wdata == 16'h000E));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mdo_valid |-> !req_ready);

  // R9
  op_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mdo_valid && !mdo_ack) |=> (mdo_valid && $stable(mdo_reg) && $stable(mdo_wdata) && $stable(mdo_read)));

  // R8
  phy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mdo_valid && $past(mdo_valid)) |-> $stable(mdo_phy));

  // R7
  err_response_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && mdo_err) |=> (rsp_done && rsp_err && rsp_rdata == 16'h0 && !mdo_valid));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
endmodule

// File: tb/mdio_indirect_seq_test.sv
module mdio_indirect_seq_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst, req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata, rsp_rdata, mdo_wdata, mdo_rdata;
  logic [4:0] phy_addr, mdo_phy, mdo_reg;
  logic rsp_done, rsp_err, mdo_valid, mdo_read, mdo_ack, mdo_err;

  mdio_indirect_seq uut (.*);

  typedef struct {
    bit wr; bit [15:0] addr; bit [15:0] data; int err_step; bit [4:0] phy; int lat;
  } req_t;

  req_t q[$];
  req_t cur;
  int checks = 0, fails = 0;

  // switch model state
  bit [15:0] mem [int];
  bit [15:0] sw_addr, sw_wdat, sw_rd;

  function automatic bit [15:0] mem_rd(bit [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (a ^ 16'h5A5A);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic req_t mk(bit wr, bit [15:0] a, bit [15:0] d, int es, bit [4:0] p, int l);
    req_t r; r.wr = wr; r.addr = a; r.data = d; r.err_step = es; r.phy = p; r.lat = l;
    return r;
  endfunction

  initial begin
    bit m_busy, m_done_next, exp_err, was_busy, fail_now;
    bit [15:0] exp_rd;
    int m_step, wcnt, cyc, idle_cnt;
    int e_reg, e_dat; bit e_rd;

    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    phy_addr = 0; mdo_ack = 0; mdo_rdata = 0; mdo_err = 0;

    q.push_back(mk(1, 16'h0000, 16'h1234, -1, 5'd3, 0));
    q.push_back(mk(0, 16'h0000, 16'h0,    -1, 5'd3, 1));
    q.push_back(mk(1, 16'hFFFF, 16'hFFFF, -1, 5'd31, 2));
    q.push_back(mk(0, 16'hFFFF, 16'h0,    -1, 5'd0, 0));
    q.push_back(mk(0, 16'h4321, 16'h0,    -1, 5'd17, 3));
    for (int s = 0; s < 4; s++) begin
      q.push_back(mk(1, 16'h0010, 16'hBEEF, s, 5'd9, s));
      q.push_back(mk(0, 16'h0010, 16'h0, -1, 5'd9, 0));
      q.push_back(mk(0, 16'h0020, 16'h0, s, 5'd10, 1));
    end
    q.push_back(mk(1, 16'h0010, 16'hABCD, -1, 5'd21, 1));
    q.push_back(mk(0, 16'h0010, 16'h0,    -1, 5'd22, 0));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(mdo_valid == 1'b0, "R1", "mdo_valid", mdo_valid, 0);
    chk(rsp_done == 1'b0,  "R1", "rsp_done", rsp_done, 0);

    m_busy = 0; m_done_next = 0; m_step = 0; wcnt = 0; cyc = 0; idle_cnt = 0;
    exp_err = 0; exp_rd = 0;
    forever begin
      // ---- compare outputs against model ----
      chk(req_ready == !m_busy, "R2", "req_ready", req_ready, !m_busy);
      chk(mdo_valid == m_busy, "R7", "mdo_valid", mdo_valid, m_busy);
      if (mdo_valid && m_busy) begin
        e_rd = 0; e_dat = -1;
        case (m_step)
          0: begin e_reg = 31; e_dat = 16'h000E; end
          1: begin e_reg = 23; e_dat = cur.addr; end
          2: if (cur.wr) begin e_reg = 24; e_dat = cur.data; end
             else begin e_reg = 21; e_dat = 16'h0001; end
          default: if (cur.wr) begin e_reg = 21; e_dat = 16'h0003; end
                   else begin e_reg = 25; e_rd = 1; end
        endcase
        if (m_step < 2) begin
          chk(mdo_reg == e_reg, m_step == 0 ? "R3" : "R4", "mdo_reg", mdo_reg, e_reg);
          chk(mdo_wdata == e_dat, m_step == 0 ? "R3" : "R4", "mdo_wdata", mdo_wdata, e_dat);
        end else begin
          chk(mdo_reg == e_reg, cur.wr ? "R5" : "R6", "mdo_reg", mdo_reg, e_reg);
          if (!e_rd) chk(mdo_wdata == e_dat, cur.wr ? "R5" : "R6", "mdo_wdata", mdo_wdata, e_dat);
        end
        chk(mdo_read == e_rd, "R6", "mdo_read", mdo_read, e_rd);
        chk(mdo_phy == cur.phy, "R8", "mdo_phy", mdo_phy, cur.phy);
      end
      chk(rsp_done == m_done_next, "R10", "rsp_done", rsp_done, m_done_next);
      if (m_done_next && rsp_done) begin
        chk(rsp_err == exp_err, "R7", "rsp_err", rsp_err, exp_err);
        chk(rsp_rdata == exp_rd, exp_err ? "R7" : (cur.wr ? "R5" : "R6"), "rsp_rdata", rsp_rdata, exp_rd);
      end

      if (cyc > 5000 || (!m_busy && q.size() == 0 && ++idle_cnt > 4)) break;
      cyc++;
      was_busy = m_busy;

      // ---- responder / switch model ----
      mdo_ack = 0; mdo_err = 0; mdo_rdata = 16'h0; m_done_next = 0;
      if (mdo_valid && m_busy) begin
        if (wcnt >= cur.lat) begin
          wcnt = 0;
          mdo_ack = 1;
          fail_now = (m_step == cur.err_step);
          if (fail_now) begin
            mdo_err = 1; mdo_rdata = 16'hDEAD;
            m_busy = 0; m_done_next = 1; exp_err = 1; exp_rd = 0;
          end else begin
            case (m_step)
              1: sw_addr = cur.addr;
              2: if (cur.wr) sw_wdat = cur.data; else sw_rd = mem_rd(sw_addr);
              3: if (cur.wr) mem[int'(sw_addr)] = sw_wdat; else mdo_rdata = sw_rd;
              default: ;
            endcase
            if (m_step == 3) begin
              m_busy = 0; m_done_next = 1; exp_err = 0;
              exp_rd = cur.wr ? 16'h0 : sw_rd;
            end else m_step++;
          end
        end else wcnt++;
      end

      // ---- stimulus ----
      if (!was_busy && q.size() > 0) begin
        cur = q.pop_front();
        req_valid = 1; req_write = cur.wr; req_addr = cur.addr;
        req_wdata = cur.data; phy_addr = cur.phy;
        m_busy = 1; m_step = 0; wcnt = 0;
      end else if (was_busy) begin
        // R2 / R8: stray request and changing port address while busy
        req_valid = cyc[0]; req_write = cyc[1];
        req_addr = 16'($urandom); req_wdata = 16'($urandom); phy_addr = 5'($urandom);
      end else begin
        req_valid = 0;
      end
      @(negedge clk);
    end

    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL R10 watchdog expired: actual=%0d expected<=5000", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule